// File: doc/BRIEF.md
# USB Host Pipe Control Register Bank

This block keeps the control word for each pipe of a host-side USB controller. There are eight pipes by default. Software cannot write a control word directly. It changes bits only through a pair of write-one strobe ports: one port sets the bits marked in its mask and the other clears them. The block also changes bits on its own when pipe events arrive. These events are a received STALL, a pipe error, an expired IN request budget, rising pipe-reset and pipe-enable levels, and bank fill or bank free notifications.

Three kinds of output come from the stored state:
- A per-pipe freeze level. It halts request generation while it is high.
- A one-cycle data-toggle reset pulse.
- Bank-switch pulses. An OUT or SETUP pipe gets a send pulse. An IN pipe gets a free pulse.

A registered read port returns the word of any pipe one cycle after the pipe index is presented.

Top module: `usb_host_pipe_ctl`

## Requirements
- R1: During synchronous reset and on the first cycle after it, every control word reads 0x00000000 and all pulse and freeze outputs are low.
- R2: `rd_data` shows, one clock after `rd_pipe` is sampled, the word of the selected pipe. The bit layout is:
  - bits 7..0, 12 and 16: interrupt enables;
  - bit 14: bank-ready flag;
  - bit 17: freeze;
  - bit 18: toggle-reset request;
  - every other bit reads zero.
- R3: An enable bit is set when its bit is one in the set strobe mask and cleared when its bit is one in the clear strobe mask. If both masks mark the same bit of the same pipe in one cycle, the bit ends up cleared.
- R4: Freeze (bit 17) becomes one on the next edge after any of these: a set strobe on bit 17, `pipe_cfg` low, a `stall_rx` pulse, `perr` high, a rising edge of `pipe_rst`, or a rising edge of `pipe_en`. Any of these events beats a clear strobe on bit 17 in the same cycle.
- R5: Freeze goes back to zero only through a clear strobe on bit 17 with no freeze event in that cycle. `freeze_o` always equals bit 17.
- R6: When freeze is released, a per-pipe budget is loaded from `inrq_cfg`. Each `in_req` pulse while the pipe is not frozen uses one unit of the budget. The request that arrives when the budget is zero, which is request number value+1, sets freeze on the next edge. Requests made while the pipe is frozen are not counted.
- R7: A set strobe on bit 18 sets the toggle-reset request. `tog_rst_o` then pulses high for exactly one cycle, on the edge after the request is set. Bit 18 clears on the edge after the pulse. A clear strobe on bit 18 has no effect.
- R8: The bank-ready flag (bit 14) is set by `bank_evt`. A set strobe on bit 14 is ignored.
- R9: A clear strobe on bit 14 while the flag is one clears it and, on the next edge, pulses `bank_send_o` for an OUT pipe (`pipe_dir_in`=0) or `bank_free_o` for an IN pipe. A `bank_evt` in the same cycle keeps the flag set and suppresses the pulse. A clear strobe while the flag is zero gives no pulse.
- R10: A strobe changes only the pipe named by its pipe index. The words of the other pipes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_we | input | 1 | Set strobe valid |
| set_pipe | input | PIPE_W | Pipe addressed by set strobe |
| set_mask | input | 32 | Bits to set |
| clr_we | input | 1 | Clear strobe valid |
| clr_pipe | input | PIPE_W | Pipe addressed by clear strobe |
| clr_mask | input | 32 | Bits to clear |
| rd_pipe | input | PIPE_W | Pipe to read |
| rd_data | output | 32 | Registered control word of `rd_pipe` |
| pipe_cfg | input | NPIPE | Pipe configured (level) |
| pipe_dir_in | input | NPIPE | 1 = IN pipe, 0 = OUT/SETUP pipe |
| stall_rx | input | NPIPE | STALL handshake received (pulse) |
| perr | input | NPIPE | Pipe error flag (level) |
| pipe_rst | input | NPIPE | Pipe reset level |
| pipe_en | input | NPIPE | Pipe enable level |
| in_req | input | NPIPE | IN request issued (pulse) |
| bank_evt | input | NPIPE | Current bank freed (OUT) or filled (IN) |
| inrq_cfg | input | NPIPE*INRQ_W | Per-pipe IN request budget |
| freeze_o | output | NPIPE | Request generation halted |
| tog_rst_o | output | NPIPE | Data-toggle reset pulse |
| bank_send_o | output | NPIPE | Send current bank and switch (OUT) |
| bank_free_o | output | NPIPE | Free current bank and switch (IN) |

## Verification
The bench targets the collisions between sources. It drives a clear strobe together with a freeze event, a set strobe together with a clear strobe on an enable bit, and a bank event together with a bank-ready clear. Each of these has a fixed winner. A design with the priority inverted would release freeze while the pipe still has an error, or would send a bank that was just refilled.

The IN budget is checked at its boundary. Freeze must appear on request number value+1. A counter that is off by one freezes one request early or one request late.

The toggle-reset pulse is checked for both width and timing. A design that drops the self-clear would give a pulse that never ends. A design that honours the clear strobe on bit 18 would lose resets.

Random strobes and events across all pipes, compared every cycle against a bench model, show up any write that leaks into another pipe.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int WORD_W    = 32;
  localparam int B_FIFOCON = 14;
  localparam int B_FREEZE  = 17;
  localparam int B_TOGRST  = 18;
  // interrupt enables: bits 7..0, 12 and 16
  localparam logic [WORD_W-1:0] ENABLE_MASK = 32'h0001_10FF;
endpackage

// File: rtl/hpc_edge_det.sv
module hpc_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/hpc_in_counter.sv
module hpc_in_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = dec && at_zero;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (dec && !at_zero) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/hpc_pipe_slice.sv
module hpc_pipe_slice
  import hpc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_hit,
  input  logic [WORD_W-1:0] set_mask,
  input  logic              clr_hit,
  input  logic [WORD_W-1:0] clr_mask,
  input  logic              cfg,
  input  logic              dir_in,
  input  logic              stall,
  input  logic              err,
  input  logic              rst_rise,
  input  logic              en_rise,
  input  logic              in_req,
  input  logic              bank_evt,
  input  logic [CNT_W-1:0]  budget,
  output logic [WORD_W-1:0] word,
  output logic              freeze,
  output logic              tog_rst,
  output logic              bank_send,
  output logic              bank_free
);
  logic [WORD_W-1:0] s_bits, c_bits;
  logic [WORD_W-1:0] en_q, en_nxt;
  logic frz_q, frz_nxt, hw_frz;
  logic fc_q, fc_nxt, do_switch;
  logic tr_q, tr_nxt, tog_q;
  logic send_q, free_q;
  logic expire, cnt_load, cnt_dec;

  assign s_bits = set_hit ? set_mask : '0;
  assign c_bits = clr_hit ? clr_mask : '0;

  assign cnt_load = frz_q && !frz_nxt;
  assign cnt_dec  = in_req && !frz_q;

  hpc_in_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (budget),
    .dec      (cnt_dec),
    .expire   (expire)
  );

  always_comb begin
    en_nxt    = ((en_q | s_bits) & ~c_bits) & ENABLE_MASK;
    hw_frz    = !cfg || stall || err || rst_rise || en_rise || expire;
    frz_nxt   = hw_frz || ((frz_q || s_bits[B_FREEZE]) && !c_bits[B_FREEZE]);
    fc_nxt    = bank_evt || (fc_q && !c_bits[B_FIFOCON]);
    do_switch = fc_q && c_bits[B_FIFOCON] && !bank_evt;
    tr_nxt    = s_bits[B_TOGRST] || (tr_q && !tog_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      frz_q  <= 1'b0;
      fc_q   <= 1'b0;
      tr_q   <= 1'b0;
      tog_q  <= 1'b0;
      send_q <= 1'b0;
      free_q <= 1'b0;
    end else begin
      en_q   <= en_nxt;
      frz_q  <= frz_nxt;
      fc_q   <= fc_nxt;
      tr_q   <= tr_nxt;
      tog_q  <= tr_q && !tog_q;
      send_q <= do_switch && !dir_in;
      free_q <= do_switch && dir_in;
    end
  end

  always_comb begin
    word           = en_q;
    word[B_FIFOCON] = fc_q;
    word[B_FREEZE]  = frz_q;
    word[B_TOGRST]  = tr_q;
  end

  assign freeze    = frz_q;
  assign tog_rst   = tog_q;
  assign bank_send = send_q;
  assign bank_free = free_q;
endmodule

// File: rtl/hpc_read_port.sv
module hpc_read_port
  import hpc_pkg::*;
#(
  parameter int NPIPE  = 8,
  parameter int PIPE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PIPE_W-1:0]       sel,
  input  logic [NPIPE*WORD_W-1:0] words,
  output logic [WORD_W-1:0]       data
);
  logic [WORD_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int k = 0; k < NPIPE; k++)
      if (sel == PIPE_W'(k)) pick = words[k*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else     data <= pick;
  end
endmodule

// File: rtl/usb_host_pipe_ctl.sv
module usb_host_pipe_ctl
  import hpc_pkg::*;
#(
  parameter int NPIPE  = 8,
  parameter int INRQ_W = 8,
  parameter int PIPE_W = (NPIPE > 1) ? $clog2(NPIPE) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    set_we,
  input  logic [PIPE_W-1:0]       set_pipe,
  input  logic [WORD_W-1:0]       set_mask,
  input  logic                    clr_we,
  input  logic [PIPE_W-1:0]       clr_pipe,
  input  logic [WORD_W-1:0]       clr_mask,
  input  logic [PIPE_W-1:0]       rd_pipe,
  output logic [WORD_W-1:0]       rd_data,
  input  logic [NPIPE-1:0]        pipe_cfg,
  input  logic [NPIPE-1:0]        pipe_dir_in,
  input  logic [NPIPE-1:0]        stall_rx,
  input  logic [NPIPE-1:0]        perr,
  input  logic [NPIPE-1:0]        pipe_rst,
  input  logic [NPIPE-1:0]        pipe_en,
  input  logic [NPIPE-1:0]        in_req,
  input  logic [NPIPE-1:0]        bank_evt,
  input  logic [NPIPE*INRQ_W-1:0] inrq_cfg,
  output logic [NPIPE-1:0]        freeze_o,
  output logic [NPIPE-1:0]        tog_rst_o,
  output logic [NPIPE-1:0]        bank_send_o,
  output logic [NPIPE-1:0]        bank_free_o
);
  logic [NPIPE-1:0]        rst_rise, en_rise;
  logic [NPIPE*WORD_W-1:0] words;

  hpc_edge_det #(.W(NPIPE)) u_rst_edge (
    .clk (clk), .rst (rst), .lvl (pipe_rst), .rise (rst_rise)
  );

  hpc_edge_det #(.W(NPIPE)) u_en_edge (
    .clk (clk), .rst (rst), .lvl (pipe_en), .rise (en_rise)
  );

  for (genvar g = 0; g < NPIPE; g++) begin : g_pipe
    logic set_hit, clr_hit;
    assign set_hit = set_we && (set_pipe == PIPE_W'(g));
    assign clr_hit = clr_we && (clr_pipe == PIPE_W'(g));

    hpc_pipe_slice #(.CNT_W(INRQ_W)) u_slice (
      .clk       (clk),
      .rst       (rst),
      .set_hit   (set_hit),
      .set_mask  (set_mask),
      .clr_hit   (clr_hit),
      .clr_mask  (clr_mask),
      .cfg       (pipe_cfg[g]),
      .dir_in    (pipe_dir_in[g]),
      .stall     (stall_rx[g]),
      .err       (perr[g]),
      .rst_rise  (rst_rise[g]),
      .en_rise   (en_rise[g]),
      .in_req    (in_req[g]),
      .bank_evt  (bank_evt[g]),
      .budget    (inrq_cfg[g*INRQ_W +: INRQ_W]),
      .word      (words[g*WORD_W +: WORD_W]),
      .freeze    (freeze_o[g]),
      .tog_rst   (tog_rst_o[g]),
      .bank_send (bank_send_o[g]),
      .bank_free (bank_free_o[g])
    );
  end

  hpc_read_port #(.NPIPE(NPIPE), .PIPE_W(PIPE_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .sel   (rd_pipe),
    .words (words),
    .data  (rd_data)
  );
endmodule

// File: rtl/hpc_pipe_ctl_chk.sv
module hpc_pipe_ctl_chk #(
  parameter int NPIPE  = 8,
  parameter int PIPE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_we,
  input logic [PIPE_W-1:0] clr_pipe,
  input logic [31:0]       clr_mask,
  input logic [NPIPE-1:0]  pipe_cfg,
  input logic [NPIPE-1:0]  stall_rx,
  input logic [NPIPE-1:0]  freeze_o,
  input logic [NPIPE-1:0]  tog_rst_o,
  input logic [NPIPE-1:0]  bank_send_o,
  input logic [NPIPE-1:0]  bank_free_o
);
  for (genvar g = 0; g < NPIPE; g++) begin : g_chk
    assert_unconfigured_freezes_R4: assert property (@(posedge clk) disable iff (rst)
      !pipe_cfg[g] |=> freeze_o[g]);

    assert_stall_freezes_R4: assert property (@(posedge clk) disable iff (rst)
      stall_rx[g] |=> freeze_o[g]);

    assert_freeze_release_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(freeze_o[g]) |-> $past(clr_we && clr_pipe == PIPE_W'(g) && clr_mask[17]));

    assert_toggle_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      tog_rst_o[g] |=> !tog_rst_o[g]);

    assert_switch_cause_R9: assert property (@(posedge clk) disable iff (rst)
      (bank_send_o[g] || bank_free_o[g]) |-> $past(clr_we && clr_pipe == PIPE_W'(g) && clr_mask[14]));
  end
endmodule

bind usb_host_pipe_ctl hpc_pipe_ctl_chk #(.NPIPE(NPIPE), .PIPE_W(PIPE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clr_we      (clr_we),
  .clr_pipe    (clr_pipe),
  .clr_mask    (clr_mask),
  .pipe_cfg    (pipe_cfg),
  .stall_rx    (stall_rx),
  .freeze_o    (freeze_o),
  .tog_rst_o   (tog_rst_o),
  .bank_send_o (bank_send_o),
  .bank_free_o (bank_free_o)
);

// File: tb/usb_host_pipe_ctl_tb.sv
module usb_host_pipe_ctl_tb;
  localparam int N  = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst;
  logic set_we, clr_we;
  logic [2:0] set_pipe, clr_pipe, rd_pipe;
  logic [31:0] set_mask, clr_mask, rd_data;
  logic [N-1:0] pipe_cfg, pipe_dir_in, stall_rx, perr, pipe_rst, pipe_en, in_req, bank_evt;
  logic [N-1:0] freeze_o, tog_rst_o, bank_send_o, bank_free_o;
  logic [CW-1:0] inrq_arr [N];
  logic [N*CW-1:0] inrq_cfg;

  int checks = 0;
  int errors = 0;
  bit started = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) inrq_cfg[i*CW +: CW] = inrq_arr[i];

  usb_host_pipe_ctl u_dut (
    .clk(clk), .rst(rst),
    .set_we(set_we), .set_pipe(set_pipe), .set_mask(set_mask),
    .clr_we(clr_we), .clr_pipe(clr_pipe), .clr_mask(clr_mask),
    .rd_pipe(rd_pipe), .rd_data(rd_data),
    .pipe_cfg(pipe_cfg), .pipe_dir_in(pipe_dir_in), .stall_rx(stall_rx), .perr(perr),
    .pipe_rst(pipe_rst), .pipe_en(pipe_en), .in_req(in_req), .bank_evt(bank_evt),
    .inrq_cfg(inrq_cfg), .freeze_o(freeze_o), .tog_rst_o(tog_rst_o),
    .bank_send_o(bank_send_o), .bank_free_o(bank_free_o)
  );

  // bench model built from the requirements
  logic [31:0] m_word [N];
  logic [CW-1:0] m_cnt [N];
  logic [N-1:0] m_tog, m_send, m_free, m_prst, m_pen;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_word[i] = '0; m_cnt[i] = '0; end
      m_tog = '0; m_send = '0; m_free = '0; m_prst = '0; m_pen = '0; m_rd = '0;
    end else begin
      logic [31:0] nw [N];
      logic [CW-1:0] nc [N];
      logic [N-1:0] nt, ns, nf;
      m_rd = m_word[rd_pipe];
      for (int i = 0; i < N; i++) begin
        logic [31:0] s, c, w;
        logic hw, fz, fc, sw, rt;
        s = (set_we && set_pipe == 3'(i)) ? set_mask : '0;
        c = (clr_we && clr_pipe == 3'(i)) ? clr_mask : '0;
        w = m_word[i];
        hw = !pipe_cfg[i] || stall_rx[i] || perr[i] || (pipe_rst[i] && !m_prst[i]) ||
             (pipe_en[i] && !m_pen[i]) || (in_req[i] && !w[17] && m_cnt[i] == 0);
        fz = hw || ((w[17] || s[17]) && !c[17]);
        fc = bank_evt[i] || (w[14] && !c[14]);
        sw = w[14] && c[14] && !bank_evt[i];
        rt = s[18] || (w[18] && !m_tog[i]);
        nt[i] = w[18] && !m_tog[i];
        ns[i] = sw && !pipe_dir_in[i];
        nf[i] = sw && pipe_dir_in[i];
        if (w[17] && !fz) nc[i] = inrq_arr[i];
        else if (in_req[i] && !w[17] && m_cnt[i] != 0) nc[i] = m_cnt[i] - 1'b1;
        else nc[i] = m_cnt[i];
        nw[i] = ((w | s) & ~c) & 32'h0001_10FF;
        nw[i][14] = fc; nw[i][17] = fz; nw[i][18] = rt;
      end
      for (int i = 0; i < N; i++) begin m_word[i] = nw[i]; m_cnt[i] = nc[i]; end
      m_tog = nt; m_send = ns; m_free = nf; m_prst = pipe_rst; m_pen = pipe_en;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("R5 freeze_o vs model", 32'(freeze_o), 32'(m_word[0][17] | {m_word[7][17],m_word[6][17],m_word[5][17],m_word[4][17],
        m_word[3][17],m_word[2][17],m_word[1][17],m_word[0][17]}));
    chk("R7 tog_rst_o vs model", 32'(tog_rst_o), 32'(m_tog));
    chk("R9 bank_send_o vs model", 32'(bank_send_o), 32'(m_send));
    chk("R9 bank_free_o vs model", 32'(bank_free_o), 32'(m_free));
    chk("R2 rd_data vs model", rd_data, m_rd);
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic quiet();
    set_we = 0; clr_we = 0; set_mask = '0; clr_mask = '0;
    stall_rx = '0; in_req = '0; bank_evt = '0;
  endtask
  task automatic do_set(int p, logic [31:0] m); set_we = 1; set_pipe = 3'(p); set_mask = m; endtask
  task automatic do_clr(int p, logic [31:0] m); clr_we = 1; clr_pipe = 3'(p); clr_mask = m; endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5173));
    rst = 1; quiet(); set_pipe = 0; clr_pipe = 0; rd_pipe = 0;
    pipe_cfg = '1; pipe_dir_in = '0; perr = '0; pipe_rst = '0; pipe_en = '0;
    for (int i = 0; i < N; i++) inrq_arr[i] = '0;
    tick(); started = 1;
    chk("R1 reset rd_data", rd_data, 32'h0);
    chk("R1 reset freeze_o", 32'(freeze_o), 32'h0);
    tick(); tick(); rst = 0;
    tick();
    chk("R1 first cycle freeze_o", 32'(freeze_o), 32'h0);

    // R2 R7 R8: full set mask on pipe 2
    do_set(2, 32'hFFFF_FFFF); rd_pipe = 2; tick(); quiet();
    tick();
    chk("R2 layout after full set", rd_data, 32'h0007_10FF);
    chk("R7 pulse high", 32'(tog_rst_o[2]), 32'h1);
    tick();
    chk("R7 pulse one cycle", 32'(tog_rst_o[2]), 32'h0);
    tick();
    chk("R7 bit 18 self-clears", rd_data, 32'h0003_10FF);

    // R3 clear wins
    do_set(3, 32'h81); do_clr(3, 32'h01); rd_pipe = 3; tick(); quiet(); tick();
    chk("R3 clear beats set", rd_data, 32'h0000_0080);

    // R10 other pipe untouched
    rd_pipe = 4; tick(); tick();
    chk("R10 pipe 4 untouched", rd_data, 32'h0);

    // R4 R5 R6 IN budget on pipe 1
    pipe_dir_in[1] = 1; inrq_arr[1] = 2;
    do_set(1, 32'h0002_0000); tick(); quiet();
    chk("R4 set strobe freezes", 32'(freeze_o[1]), 32'h1);
    do_clr(1, 32'h0002_0000); tick(); quiet();
    chk("R5 clear strobe releases", 32'(freeze_o[1]), 32'h0);
    for (int k = 0; k < 3; k++) begin
      in_req[1] = 1; tick(); in_req = '0;
      chk("R6 budget boundary", 32'(freeze_o[1]), (k == 2) ? 32'h1 : 32'h0);
    end

    // R7 clear strobe on bit 18 ignored
    do_set(5, 32'h0004_0000); do_clr(5, 32'h0004_0000); tick(); quiet(); tick();
    chk("R7 clear on bit 18 ignored", 32'(tog_rst_o[5]), 32'h1);

    // R8 R9 OUT pipe 6
    do_set(6, 32'h0000_4000); rd_pipe = 6; tick(); quiet(); tick();
    chk("R8 set strobe on bit 14 ignored", rd_data, 32'h0);
    bank_evt[6] = 1; tick(); quiet(); tick();
    chk("R8 bank event sets flag", rd_data, 32'h0000_4000);
    do_clr(6, 32'h0000_4000); tick(); quiet();
    chk("R9 OUT send pulse", {bank_free_o[6], bank_send_o[6]}, 32'h1);
    tick();
    chk("R9 send pulse ends", 32'(bank_send_o[6]), 32'h0);

    // R9 IN pipe 7
    pipe_dir_in[7] = 1;
    bank_evt[7] = 1; tick();
    do_clr(7, 32'h0000_4000); tick(); quiet();
    chk("R9 bank event overrides clear", 32'(bank_free_o[7]), 32'h0);
    do_clr(7, 32'h0000_4000); tick(); quiet();
    chk("R9 IN free pulse", {bank_send_o[7], bank_free_o[7]}, 32'h1);
    do_clr(7, 32'h0000_4000); tick(); quiet();
    chk("R9 clear on empty flag no pulse", 32'(bank_free_o[7]), 32'h0);

    // R4 freeze causes on pipe 0
    stall_rx[0] = 1; tick(); quiet();
    chk("R4 stall freezes", 32'(freeze_o[0]), 32'h1);
    perr[0] = 1; do_clr(0, 32'h0002_0000); tick(); quiet();
    chk("R4 error beats clear", 32'(freeze_o[0]), 32'h1);
    perr[0] = 0; do_clr(0, 32'h0002_0000); tick(); quiet();
    chk("R5 release after error gone", 32'(freeze_o[0]), 32'h0);
    pipe_en[0] = 1; tick();
    chk("R4 enable rising freezes", 32'(freeze_o[0]), 32'h1);
    do_clr(0, 32'h0002_0000); tick(); quiet();
    chk("R4 enable level alone no freeze", 32'(freeze_o[0]), 32'h0);
    pipe_rst[0] = 1; tick();
    chk("R4 reset rising freezes", 32'(freeze_o[0]), 32'h1);
    pipe_cfg[0] = 0; do_clr(0, 32'h0002_0000); tick(); quiet();
    chk("R4 unconfigured beats clear", 32'(freeze_o[0]), 32'h1);
    pipe_cfg[0] = 1;

    // constrained random phase, checked every cycle against the model
    for (int i = 0; i < N; i++) inrq_arr[i] = CW'($urandom_range(0, 3));
    for (int cyc = 0; cyc < 4000; cyc++) begin
      set_we = ($urandom_range(0, 3) == 0);
      set_pipe = 3'($urandom_range(0, 7));
      set_mask = $urandom();
      clr_we = ($urandom_range(0, 2) == 0);
      clr_pipe = 3'($urandom_range(0, 7));
      clr_mask = $urandom();
      rd_pipe = 3'($urandom_range(0, 7));
      for (int i = 0; i < N; i++) begin
        pipe_cfg[i] = ($urandom_range(0, 15) != 0);
        stall_rx[i] = ($urandom_range(0, 31) == 0);
        perr[i]     = ($urandom_range(0, 31) == 0);
        in_req[i]   = ($urandom_range(0, 1) == 0);
        bank_evt[i] = ($urandom_range(0, 7) == 0);
        if ($urandom_range(0, 19) == 0) pipe_rst[i] = ~pipe_rst[i];
        if ($urandom_range(0, 19) == 0) pipe_en[i]  = ~pipe_en[i];
        if ($urandom_range(0, 49) == 0) pipe_dir_in[i] = ~pipe_dir_in[i];
      end
      tick();
    end
    quiet();
    tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule